// File: doc/BRIEF.md
# Free-Running Timer with Capture and Compare Channels

This block is a 16-bit up-counter that never stops on its own and is shared by four capture channels and four compare channels. The counter advances on a count strobe. The strobe comes either from an internal divider that gives the system clock divided by a power of two between 1 and 128, or from the synchronized rising edges of an external clock pin. When the counter rolls over from all ones to zero it raises an overflow flag. When compare channel 0 matches and the clear option is on, the counter returns to zero on that step instead of advancing.

Each compare channel watches its own 16-bit register and raises a flag on a match. Compare channels are grouped in pairs, and each pair toggles one output pin. The two register values of a pair therefore place the rising and falling edges of a waveform. Each capture channel synchronizes its input pin, detects the edge selected for it, copies the counter value into its capture register and raises a flag. All flags are sticky and are ORed onto one interrupt line. Software reaches the block over a single-cycle write port with a combinational read port.

A two-state run controller sits at the centre. **STOP** is the reset state. The **START** transition moves it to **RUN** when the control register is written with the run bit set. The **HALT** transition moves it back to **STOP** when the control register is written with the run bit clear. The counter can advance only in RUN.

Top module: `frt_timer`

## Requirements
- R1: After reset, every register reads zero, the controller is in STOP, the pair outputs are low and irq is low. The address map is: 0 control, 1 capture configuration, 2 flags, 3 counter, 4 to 7 compare channels 0 to 3, 8 to 11 capture channels 0 to 3.
- R2: Control bits [2:0] hold the divide exponent n, bit 3 selects the external clock, bit 4 is run and bit 5 enables clear on compare. In RUN with the internal clock, the counter reads start + floor(t/2^n) t cycles after the last write to the control or counter register. Writing the counter loads it. In STOP the counter holds its value.
- R3: A step from 0xFFFF wraps the counter to 0 and sets flag bit 0.
- R4: With bit 5 set, a step taken while the counter equals compare 0 loads 0 instead of advancing. This clear does not set flag bit 0.
- R5: A step taken while the counter equals compare register i sets flag bit 1+i.
- R6: cmp_out[k] toggles on every step that matches compare channel 2k or 2k+1.
- R7: Capture channel i stores the counter value of the cycle in which its synchronized edge is detected, and sets flag bit 5+i. A pin change made before clock edge E is stored at edge E+2.
- R8: Flags are sticky. Writing the flag register clears each bit written 0 and keeps each bit written 1. An event in the same cycle as the clear wins.
- R9: With control bit 3 set, the counter steps once for each rising edge of ext_clk, after a three-edge synchronizer and detector delay, and n is ignored.
- R10: irq is high exactly when any flag bit is set.
- R11: Capture configuration bits [2i+1:2i] select the edges for channel i: 00 none, 01 rising, 10 falling, 11 both. An edge that is not selected leaves the capture register and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap_in | input | 4 | Capture inputs, asynchronous |
| cmp_out | output | 2 | Pair-toggled compare outputs |
| irq | output | 1 | OR of all flags |

## Verification
The checker checks on every cycle the step-level rules: the wrap to zero with the overflow flag, the clear on compare 0, that a match sets its flag and toggles its pair output, that a capture copies the counter of the detecting cycle, that flags never drop without a flag write, and that the counter holds in STOP. Other behaviour shows only in the bench's scenarios. These are the exact count sequence for each of the eight divider settings, the three-edge synchronizer delays on the capture and external clock pins, the sixteen combinations of edge mode and capture channel, the period of the clear-on-compare loop, and the case where an event lands in the same cycle as a flag clear.

// File: rtl/frt_pkg.sv
package frt_pkg;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } frt_state_e;

    localparam int A_CTRL   = 0;
    localparam int A_CAPCFG = 1;
    localparam int A_FLAGS  = 2;
    localparam int A_COUNT  = 3;
    localparam int A_CMP0   = 4;

endpackage

// File: rtl/frt_edge_sync.sv
module frt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic edge_seen
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl       = sync_q;
    assign edge_seen = sync_q ^ prev_q;

endmodule

// File: rtl/frt_tick_gen.sv
module frt_tick_gen #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic            ext_sel,
    input  logic            ext_rise,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = DIV_W'((32'd1 << sel) - 32'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || restart) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && (ext_sel ? ext_rise : ((div_q & mask) == mask));

endmodule

// File: rtl/frt_timer.sv
module frt_timer
    import frt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_CAP  = 4,
    parameter int N_CMP  = 4,
    parameter int PS_W   = 3,
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   rdata,
    input  logic               ext_clk,
    input  logic [N_CAP-1:0]   cap_in,
    output logic [N_CMP/2-1:0] cmp_out,
    output logic               irq
);

    localparam int PAIRS    = N_CMP / 2;
    localparam int FLAG_W   = 1 + N_CMP + N_CAP;
    localparam int CAP_BASE = A_CMP0 + N_CMP;
    localparam int EXT_BIT  = PS_W;
    localparam int RUN_BIT  = PS_W + 1;
    localparam int CLR_BIT  = PS_W + 2;
    localparam int CFG_W    = PS_W + 2;

    frt_state_e state_q, state_d;
    logic                        running;
    logic [CFG_W-1:0]            ctrl_q;
    logic [2*N_CAP-1:0]          capcfg_q;
    logic [FLAG_W-1:0]           flags_q;
    logic [FLAG_W-1:0]           flag_ev;
    logic [FLAG_W-1:0]           flag_keep;
    logic [CNT_W-1:0]            cnt_q;
    logic [N_CMP-1:0][CNT_W-1:0] cmp_q;
    logic [N_CAP-1:0][CNT_W-1:0] cap_q;
    logic [N_CMP-1:0]            cmp_ev;
    logic [N_CAP-1:0]            cap_ev;
    logic [N_CAP-1:0]            cap_lvl;
    logic [N_CAP-1:0]            cap_edge;
    logic [PAIRS-1:0]            out_q;
    logic                        ext_lvl, ext_edge;
    logic                        tick, clr_en, clr_hit, wrap;
    logic                        wr_ctrl, wr_capcfg, wr_flags, wr_count;

    assign wr_ctrl   = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_capcfg = wr_en && (addr == ADDR_W'(A_CAPCFG));
    assign wr_flags  = wr_en && (addr == ADDR_W'(A_FLAGS));
    assign wr_count  = wr_en && (addr == ADDR_W'(A_COUNT));

    // Run controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (wr_ctrl && wdata[RUN_BIT])  state_d = ST_RUN;  // START
            ST_RUN:  if (wr_ctrl && !wdata[RUN_BIT]) state_d = ST_STOP; // HALT
        endcase
    end

    // Run controller: outputs
    always_comb begin
        running = 1'b0;
        unique case (state_q)
            ST_STOP: running = 1'b0;
            ST_RUN:  running = 1'b1;
        endcase
    end

    frt_edge_sync u_ext_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (ext_clk),
        .lvl       (ext_lvl),
        .edge_seen (ext_edge)
    );

    frt_tick_gen #(.PS_W(PS_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .restart  (wr_ctrl || wr_count),
        .ext_sel  (ctrl_q[EXT_BIT]),
        .ext_rise (ext_edge && ext_lvl),
        .sel      (ctrl_q[PS_W-1:0]),
        .tick     (tick)
    );

    generate
        for (genvar gi = 0; gi < N_CAP; gi++) begin : g_cap
            frt_edge_sync u_cap_sync (
                .clk       (clk),
                .rst_n     (rst_n),
                .din       (cap_in[gi]),
                .lvl       (cap_lvl[gi]),
                .edge_seen (cap_edge[gi])
            );
            assign cap_ev[gi] = cap_edge[gi] &&
                ((cap_lvl[gi] && capcfg_q[2*gi]) || (!cap_lvl[gi] && capcfg_q[2*gi+1]));
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < N_CMP; i++) begin
            cmp_ev[i] = tick && (cnt_q == cmp_q[i]);
        end
    end

    assign clr_en    = ctrl_q[CLR_BIT - 1];
    assign clr_hit   = clr_en && cmp_ev[0];
    assign wrap      = tick && (cnt_q == {CNT_W{1'b1}}) && !clr_hit;
    assign flag_ev   = {cap_ev, cmp_ev, wrap};
    assign flag_keep = wr_flags ? wdata[FLAG_W-1:0] : {FLAG_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            capcfg_q <= '0;
            flags_q  <= '0;
            cnt_q    <= '0;
            cmp_q    <= '0;
            cap_q    <= '0;
            out_q    <= '0;
        end else begin
            if (wr_ctrl)   ctrl_q   <= {wdata[CLR_BIT], wdata[EXT_BIT:0]};
            if (wr_capcfg) capcfg_q <= wdata[2*N_CAP-1:0];
            flags_q <= flag_ev | (flags_q & flag_keep);
            if (wr_count)     cnt_q <= wdata;
            else if (clr_hit) cnt_q <= '0;
            else if (tick)    cnt_q <= cnt_q + 1'b1;
            for (int i = 0; i < N_CMP; i++) begin
                if (wr_en && addr == ADDR_W'(A_CMP0 + i)) cmp_q[i] <= wdata;
            end
            for (int i = 0; i < N_CAP; i++) begin
                if (cap_ev[i]) cap_q[i] <= cnt_q;
            end
            for (int k = 0; k < PAIRS; k++) begin
                out_q[k] <= out_q[k] ^ (cmp_ev[2*k] | cmp_ev[2*k+1]);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL)) begin
            rdata[CLR_BIT]    = clr_en;
            rdata[RUN_BIT]    = running;
            rdata[EXT_BIT:0]  = ctrl_q[EXT_BIT:0];
        end
        if (addr == ADDR_W'(A_CAPCFG)) rdata[2*N_CAP-1:0] = capcfg_q;
        if (addr == ADDR_W'(A_FLAGS))  rdata[FLAG_W-1:0]  = flags_q;
        if (addr == ADDR_W'(A_COUNT))  rdata = cnt_q;
        for (int i = 0; i < N_CMP; i++) begin
            if (addr == ADDR_W'(A_CMP0 + i)) rdata = cmp_q[i];
        end
        for (int i = 0; i < N_CAP; i++) begin
            if (addr == ADDR_W'(CAP_BASE + i)) rdata = cap_q[i];
        end
    end

    assign cmp_out = out_q;
    assign irq     = |flags_q;

endmodule

// File: rtl/frt_timer_chk.sv
module frt_timer_chk
    import frt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_CAP  = 4,
    parameter int N_CMP  = 4,
    parameter int ADDR_W = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic                        running,
    input logic                        tick,
    input logic                        clr_en,
    input logic [CNT_W-1:0]            cnt_q,
    input logic [N_CMP-1:0]            cmp_ev,
    input logic [N_CAP-1:0]            cap_ev,
    input logic [N_CAP-1:0][CNT_W-1:0] cap_q,
    input logic [N_CAP+N_CMP:0]        flags_q,
    input logic [N_CMP/2-1:0]          cmp_out
);

    logic wr_cnt, wr_flg;
    assign wr_cnt = wr_en && (addr == ADDR_W'(A_COUNT));
    assign wr_flg = wr_en && (addr == ADDR_W'(A_FLAGS));

    a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_cnt) |=> $stable(cnt_q));

    a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == {CNT_W{1'b1}} && !(clr_en && cmp_ev[0]) && !wr_cnt)
        |=> (cnt_q == '0 && flags_q[0]));

    a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && cmp_ev[0] && !wr_cnt) |=> (cnt_q == '0));

    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flg |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    generate
        for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
            a_r5_cmp_flag: assert property (@(posedge clk) disable iff (!rst_n)
                cmp_ev[i] |=> flags_q[1+i]);
        end
        for (genvar k = 0; k < N_CMP/2; k++) begin : g_pair
            a_r6_pair_toggle: assert property (@(posedge clk) disable iff (!rst_n)
                (cmp_ev[2*k] || cmp_ev[2*k+1]) |=> (cmp_out[k] != $past(cmp_out[k])));
        end
        for (genvar i = 0; i < N_CAP; i++) begin : g_cap
            a_r7_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
                cap_ev[i] |=> (cap_q[i] == $past(cnt_q) && flags_q[1+N_CMP+i]));
        end
    endgenerate

endmodule

bind frt_timer frt_timer_chk #(
    .CNT_W  (CNT_W),
    .N_CAP  (N_CAP),
    .N_CMP  (N_CMP),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .running (running),
    .tick    (tick),
    .clr_en  (clr_en),
    .cnt_q   (cnt_q),
    .cmp_ev  (cmp_ev),
    .cap_ev  (cap_ev),
    .cap_q   (cap_q),
    .flags_q (flags_q),
    .cmp_out (cmp_out)
);

// File: tb/frt_timer_tb_top.sv
`timescale 1ns/1ps
module frt_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ext_clk = 1'b0;
    logic [3:0]  cap_in = '0;
    logic [1:0]  cmp_out;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    localparam logic [3:0] AD_CTRL = 4'd0, AD_CFG = 4'd1, AD_FLG = 4'd2, AD_CNT = 4'd3;
    localparam logic [15:0] RUN = 16'h0010, EXT = 16'h0008, CLR = 16'h0020;

    frt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_clk(ext_clk), .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int v;
        int cmpv [4];
        int capexp [4];
        cmpv = '{1000, 1010, 2000, 2005};
        capexp = '{0, 0, 0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state over the whole map
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset outputs", int'(cmp_out), 0);
        check("R10 irq low after reset", int'(irq), 0);
        @(negedge clk);

        for (int i = 0; i < 4; i++) wr(4'(4 + i), 16'(cmpv[i]));

        // R2 divider sweep
        for (int n = 0; n < 8; n++) begin
            wr(AD_CTRL, RUN | 16'(n));
            wr(AD_CNT, 16'd100);
            for (int t = 0; t < 40; t++) begin
                rd(AD_CNT, v);
                check("R2 prescaled count", v, 100 + (t >> n));
                @(negedge clk);
            end
        end

        // R2 hold in STOP
        wr(AD_CTRL, 16'h0);
        wr(AD_CNT, 16'd77);
        repeat (10) @(negedge clk);
        rd(AD_CNT, v);
        check("R2 stopped counter holds", v, 77);

        // R3 overflow
        wr(AD_FLG, 16'h0);
        wr(AD_CTRL, RUN);
        wr(AD_CNT, 16'hFFFD);
        for (int t = 0; t < 4; t++) begin
            rd(AD_CNT, v);
            check("R3 wrap count", v, (16'hFFFD + t) & 16'hFFFF);
            rd(AD_FLG, v);
            check("R3 overflow flag", v & 1, (t >= 3) ? 1 : 0);
            @(negedge clk);
        end
        check("R10 irq with overflow", int'(irq), 1);

        // R5 R6 compare pairs
        for (int k = 0; k < 2; k++) begin
            int a0, b0, st, fexp, oexp;
            a0 = cmpv[2*k]; b0 = cmpv[2*k+1];
            st = a0 - 5;
            oexp = int'(cmp_out[k]);
            fexp = 0;
            wr(AD_CTRL, 16'h0);
            wr(AD_FLG, 16'h0);
            wr(AD_CTRL, RUN);
            wr(AD_CNT, 16'(st));
            for (int t = 0; t < 24; t++) begin
                if (t > 0) begin
                    int p;
                    p = st + t - 1;
                    if (p == a0) begin oexp ^= 1; fexp |= 1 << (1 + 2*k); end
                    if (p == b0) begin oexp ^= 1; fexp |= 1 << (2 + 2*k); end
                end
                rd(AD_CNT, v);
                check("R5 compare count", v, st + t);
                rd(AD_FLG, v);
                check("R5 compare flags", v, fexp);
                check("R6 pair output", int'(cmp_out[k]), oexp);
                check("R10 irq follows flags", int'(irq), (fexp != 0) ? 1 : 0);
                @(negedge clk);
            end
        end

        // R4 clear on compare 0
        for (int n = 0; n < 3; n++) begin
            wr(AD_CTRL, 16'h0);
            wr(AD_FLG, 16'h0);
            wr(4'd4, 16'd20);
            wr(AD_CTRL, RUN | CLR | 16'(n));
            wr(AD_CNT, 16'd15);
            for (int t = 0; t < 60; t++) begin
                rd(AD_CNT, v);
                check("R4 clear-on-compare sequence", v, (15 + (t >> n)) % 21);
                @(negedge clk);
            end
            rd(AD_FLG, v);
            check("R4 no overflow flag on clear", v & 1, 0);
        end

        // R8 event wins over clear, write-1 keeps
        wr(AD_CTRL, 16'h0);
        wr(AD_FLG, 16'h0);
        wr(AD_CTRL, RUN);
        wr(AD_CNT, 16'd1008);
        repeat (2) @(negedge clk);
        wr(AD_FLG, 16'h0);
        wr(AD_CTRL, 16'h0);
        rd(AD_FLG, v);
        check("R8 event beats clear", v, 16'h0004);
        @(negedge clk);
        wr(AD_FLG, 16'hFFFF);
        rd(AD_FLG, v);
        check("R8 write one keeps", v, 16'h0004);
        @(negedge clk);
        wr(AD_FLG, 16'hFFFB);
        rd(AD_FLG, v);
        check("R8 write zero clears", v, 0);
        check("R10 irq low when clear", int'(irq), 0);
        @(negedge clk);

        // R7 R11 capture modes, counter stopped
        for (int m = 0; m < 4; m++) begin
            for (int ch = 0; ch < 4; ch++) begin
                int v2;
                wr(AD_CFG, 16'(m << (2*ch)));
                wr(AD_FLG, 16'h0);
                v2 = 16'h1000 + m*16 + ch;
                wr(AD_CNT, 16'(v2));
                cap_in[ch] = 1'b1;
                repeat (4) @(negedge clk);
                if ((m & 1) != 0) capexp[ch] = v2;
                rd(4'(8 + ch), v);
                check("R11 rising-edge capture value", v, capexp[ch]);
                rd(AD_FLG, v);
                check("R7 rising-edge capture flag", v, ((m & 1) != 0) ? (1 << (5 + ch)) : 0);
                @(negedge clk);
                wr(AD_FLG, 16'h0);
                v2 = v2 + 16'h100;
                wr(AD_CNT, 16'(v2));
                cap_in[ch] = 1'b0;
                repeat (4) @(negedge clk);
                if ((m & 2) != 0) capexp[ch] = v2;
                rd(4'(8 + ch), v);
                check("R11 falling-edge capture value", v, capexp[ch]);
                rd(AD_FLG, v);
                check("R7 falling-edge capture flag", v, ((m & 2) != 0) ? (1 << (5 + ch)) : 0);
                @(negedge clk);
            end
        end

        // R7 capture while counting: stored value is count two edges after the pin change
        wr(AD_CFG, 16'h0001);
        wr(AD_FLG, 16'h0);
        wr(AD_CTRL, RUN);
        wr(AD_CNT, 16'd500);
        cap_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd(4'd8, v);
        check("R7 capture timing while running", v, 502);
        cap_in[0] = 1'b0;
        @(negedge clk);

        // R9 external clock, divider setting ignored
        wr(AD_CTRL, RUN | EXT | 16'd5);
        wr(AD_CNT, 16'd0);
        ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        rd(AD_CNT, v);
        check("R9 ext latency before step", v, 0);
        @(negedge clk);
        rd(AD_CNT, v);
        check("R9 ext first step", v, 1);
        ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 9; p++) begin
            ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        rd(AD_CNT, v);
        check("R9 ext edge count", v, 10);
        repeat (10) @(negedge clk);
        rd(AD_CNT, v);
        check("R9 no step without ext edge", v, 10);

        done = 1;
        summary();
    end

endmodule